// File: doc/BRIEF.md
# Cascaded Two-Stage Interval Tick Generator

This block produces a periodic interrupt request from a slow timebase enable, usually a 64 kHz pulse. It chains two 16-bit down-counters. The first stage is a prescaler. It counts tick pulses and, each time its period is used up, reloads itself from its programmed divider and sends one step to the second stage. The second stage counts those steps. When a step finds it already at zero, it raises a one-cycle interrupt request and wraps around through the full 16-bit range. For example, a prescaler divider of 64000 gives the second stage a 1 Hz step. The second stage then sets how many seconds pass between interrupts.

Software programs each stage through a byte-wide write port. It writes the low byte first and then the high byte. The value takes effect only when the high byte arrives. While either stage holds a half-written value, the whole chain is frozen. A control write abandons any half-written value, so that the next data write is taken as a low byte again.

Top module: `tick_cascade`

## Requirements
- R1: After reset, irq_o is low. No interrupt can occur until both stages have received a complete two-byte value.
- R2: While running, the prescaler decrements on every cycle with tick_en high and holds otherwise. A tick that finds it at 1 or 0 reloads it from its divider and issues one step. A divider D of 1 or more therefore steps once per D ticks, and a divider of 0 steps on every tick.
- R3: Each step decrements the second stage. A step that finds it at 0 raises the interrupt and leaves the count at 65535. A loaded count N therefore gives its first interrupt on step N+1, and every later interrupt 65536 steps apart.
- R4: irq_o is high for exactly one clock cycle, in the cycle that follows the clock edge that sampled the causing tick.
- R5: Writing to address 0 (prescaler) or address 1 (second stage) stores wr_data as the low byte first and as the high byte second. On the high-byte write, the 16-bit value {high, low} becomes the new count, and for the prescaler it also becomes the divider.
- R6: While either stage has a low byte written and its high byte still outstanding, neither stage counts. Ticks that arrive during that time are lost.
- R7: A write to address 2 (control) discards any pending low byte in both stages. Counting resumes with the previously loaded values, and the next data write to a stage is taken as its low byte.
- R8: A write to address 3 has no effect on counting or on irq_o.
- R9: Reloading the prescaler while the chain is running restarts the prescaler count from the new value. The second stage count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase pulse, one cycle wide per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 prescaler data, 1 second-stage data, 2 control, 3 unused |
| wr_data | input | 8 | Write data byte |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The in-RTL assertions check the following on every cycle:
- irq_o never lasts two cycles.
- A step that finds the second stage at zero leaves it at 65535 with the interrupt raised.
- The prescaler holds its count while the chain is held.
- No step is issued while a byte is pending.
- The byte pointer advances and clears as it should.

Only the bench's scenarios can show the end-to-end periods:
- The interrupt arrives on tick (N+1)·D.
- The 65536-step wrap period.
- Divider 0.
- Ticks spaced by idle cycles.
- The loss of ticks during a pending load.
- The control-write recovery.
- That address 3 is harmless.

A behavioural model in the bench is compared against irq_o on every clock.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PRE  = 2'd0,
        ADR_POST = 2'd1,
        ADR_CTL  = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tick_load.sv
module tick_load #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_we,
    input  logic                  clr_ptr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  load_stb,
    output logic [2*DATA_W-1:0]   load_val,
    output logic                  pend,
    output logic                  armed
);
    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic              ptr;
        logic              armed;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_ptr) begin
            st_d.ptr = 1'b0;
        end else if (data_we) begin
            if (!st_q.ptr) begin
                st_d.lo  = wr_data;
                st_d.ptr = 1'b1;
            end else begin
                st_d.ptr   = 1'b0;
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_stb = data_we && !clr_ptr && st_q.ptr;
    assign load_val = {wr_data, st_q.lo};
    assign pend     = st_q.ptr;
    assign armed    = st_q.armed;

    // R5: a low-byte write leaves the high byte outstanding
    a_r5_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        data_we && !clr_ptr && !st_q.ptr |=> st_q.ptr);
    // R7: a control write leaves nothing pending
    a_r7_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ptr |=> !st_q.ptr);
endmodule

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] div;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       at_end;

    assign at_end = (st_q.cnt <= CNT_W'(1));

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.div = load_val;
            st_d.cnt = load_val;
        end else if (tick && run) begin
            if (at_end) begin
                st_d.cnt = st_q.div;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a held chain keeps the prescaler count
    a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(st_q.cnt));
    // R2: after an expiry the count restarts from the divider
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.cnt == $past(st_q.div));
endmodule

// File: rtl/tick_postscale.sv
module tick_postscale #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             irq
);
    localparam int unsigned EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } post_state_t;

    post_state_t      st_d, st_q;
    logic [EXT_W-1:0] base;
    logic [EXT_W-1:0] dec;

    always_comb begin
        base = (st_q.cnt == '0) ? (EXT_W'(1) << CNT_W) : {1'b0, st_q.cnt};
        dec  = base - EXT_W'(1);
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (step) begin
            st_d.cnt = dec[CNT_W-1:0];
            st_d.irq = (st_q.cnt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    // R4: the request never stays high two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);
    // R3: a step at zero wraps to all ones and requests
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && st_q.cnt == '0 |=> st_q.cnt == '1 && st_q.irq);
endmodule

// File: rtl/tick_cascade.sv
module tick_cascade
    import tick_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_o
);
    localparam int unsigned CNT_W  = 2 * DATA_W;
    localparam int unsigned STAGES = 2;

    reg_addr_e               addr;
    logic                    ctl_we;
    logic [STAGES-1:0]       data_we;
    logic [STAGES-1:0]       load_stb;
    logic [STAGES-1:0]       pend;
    logic [STAGES-1:0]       armed;
    logic [CNT_W-1:0]        load_val [STAGES];
    logic                    run;
    logic                    step;

    assign addr       = reg_addr_e'(wr_addr);
    assign ctl_we     = wr_en && (addr == ADR_CTL);
    assign data_we[0] = wr_en && (addr == ADR_PRE);
    assign data_we[1] = wr_en && (addr == ADR_POST);

    for (genvar s = 0; s < STAGES; s++) begin : g_load
        tick_load #(.DATA_W(DATA_W)) u_load (
            .clk      (clk),
            .rst_n    (rst_n),
            .data_we  (data_we[s]),
            .clr_ptr  (ctl_we),
            .wr_data  (wr_data),
            .load_stb (load_stb[s]),
            .load_val (load_val[s]),
            .pend     (pend[s]),
            .armed    (armed[s])
        );
    end

    assign run = (&armed) && !(|pend);

    tick_prescale #(.CNT_W(CNT_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .run      (run),
        .load     (load_stb[0]),
        .load_val (load_val[0]),
        .expire   (step)
    );

    tick_postscale #(.CNT_W(CNT_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load_stb[1]),
        .load_val (load_val[1]),
        .irq      (irq_o)
    );

    // R1: no request before the second stage has a full value
    a_r1_idle_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed[1] |-> !irq_o);
    // R6: no step reaches the second stage while a byte is pending
    a_r6_no_step_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> !step);
endmodule

// File: tb/tb_tick_cascade.sv
`timescale 1ns/1ps
module tb_tick_cascade;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tick_cascade dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_o   (irq_o)
    );

    // behavioural reference
    int m_alo, m_blo, m_adiv, m_acnt, m_bcnt;
    bit m_aptr, m_bptr, m_aarm, m_barm, m_irq;

    always @(posedge clk) begin
        bit running, lda, ldb, stp;
        if (!rst_n) begin
            m_alo = 0; m_blo = 0; m_adiv = 0; m_acnt = 0; m_bcnt = 0;
            m_aptr = 0; m_bptr = 0; m_aarm = 0; m_barm = 0; m_irq = 0;
        end else begin
            running = m_aarm && m_barm && !m_aptr && !m_bptr;
            lda = 0; ldb = 0; stp = 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: if (!m_aptr) begin m_alo = wr_data; m_aptr = 1; end
                          else begin m_adiv = wr_data * 256 + m_alo; m_acnt = m_adiv;
                                     m_aptr = 0; m_aarm = 1; lda = 1; end
                    2'd1: if (!m_bptr) begin m_blo = wr_data; m_bptr = 1; end
                          else begin m_bcnt = wr_data * 256 + m_blo;
                                     m_bptr = 0; m_barm = 1; ldb = 1; end
                    2'd2: begin m_aptr = 0; m_bptr = 0; end
                    default: ;
                endcase
            end
            if (tick_en && running && !lda) begin
                if (m_acnt <= 1) begin m_acnt = m_adiv; stp = 1; end
                else m_acnt = m_acnt - 1;
            end
            m_irq = 0;
            if (stp && !ldb) begin
                if (m_bcnt == 0) begin m_irq = 1; m_bcnt = 65535; end
                else m_bcnt = m_bcnt - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (irq_o !== m_irq) begin
                fails++;
                $display("FAIL R4 per-cycle irq_o act=%0b exp=%0b", irq_o, m_irq);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ld(input int a, input int b);
        wr(2'd0, a[7:0]); wr(2'd0, a[15:8]);
        wr(2'd1, b[7:0]); wr(2'd1, b[15:8]);
    endtask

    task automatic run_ticks(input int n, input int gap,
                             output int first, output int last, output int pulses);
        first = 0; last = 0; pulses = 0;
        for (int k = 1; k <= n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            if (irq_o) begin pulses++; last = k; if (first == 0) first = k; end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (irq_o) pulses++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int f, l, p;
        repeat (3) @(negedge clk);
        check(irq_o === 1'b0, "R1 reset irq", irq_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing loaded
        run_ticks(20, 0, f, l, p);
        check(p == 0, "R1 unloaded pulses", p, 0);
        wr(2'd0, 8'd1); wr(2'd0, 8'd0);
        run_ticks(10, 0, f, l, p);
        check(p == 0, "R1 only prescaler loaded", p, 0);
        // R2 R3 R4 R5
        ld(3, 2);
        run_ticks(12, 0, f, l, p);
        check(f == 9, "R3 first irq tick", f, 9);
        check(p == 1, "R4 single pulse", p, 1);
        // R2 spaced ticks
        ld(3, 2);
        run_ticks(12, 2, f, l, p);
        check(f == 9, "R2 spaced ticks first irq", f, 9);
        check(p == 1, "R4 spaced pulse count", p, 1);
        // R2 divider zero
        ld(0, 1);
        run_ticks(3, 0, f, l, p);
        check(f == 2, "R2 divider zero", f, 2);
        // R3 wrap period
        ld(1, 0);
        run_ticks(65540, 0, f, l, p);
        check(f == 1, "R3 wrap first", f, 1);
        check(l == 65537, "R3 wrap second", l, 65537);
        check(p == 2, "R3 wrap pulse count", p, 2);
        // R6 pending hold
        ld(2, 1);
        wr(2'd0, 8'd5);
        run_ticks(20, 0, f, l, p);
        check(p == 0, "R6 held while pending", p, 0);
        wr(2'd0, 8'd0);
        run_ticks(12, 0, f, l, p);
        check(f == 10, "R6 after completion", f, 10);
        // R7 control clears pointer
        ld(2, 1);
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h00);
        run_ticks(6, 0, f, l, p);
        check(f == 4, "R7 resume old values", f, 4);
        wr(2'd0, 8'd4); wr(2'd0, 8'd0);
        wr(2'd1, 8'd1); wr(2'd1, 8'd0);
        run_ticks(10, 0, f, l, p);
        check(f == 8, "R7 next write is low byte", f, 8);
        // R8 unused address
        ld(2, 1);
        wr(2'd3, 8'hFF);
        run_ticks(6, 0, f, l, p);
        check(f == 4, "R8 address 3 ignored", f, 4);
        // R9 prescaler reload mid-run
        ld(4, 0);
        run_ticks(2, 0, f, l, p);
        check(p == 0, "R9 before reload", p, 0);
        wr(2'd0, 8'd3); wr(2'd0, 8'd0);
        run_ticks(5, 0, f, l, p);
        check(f == 3, "R9 after reload", f, 3);
        // R5 full 16-bit second-stage value
        ld(1, 300);
        run_ticks(305, 0, f, l, p);
        check(f == 301, "R5 sixteen-bit load", f, 301);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule